// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This peripheral keeps wall time as a plain count of seconds. A one-cycle enable pulse arriving at 32.768 kHz feeds a programmable prescaler; each time the prescaler wraps it produces a seconds tick that advances a 32-bit counter. Software reads and loads the counter, programs an alarm value, and watches a four-bit status word in which two sticky event flags sit beside two interrupt enables.

Access is through a simple single-cycle register port: a select, a write strobe, an address and write data, with read data returned combinationally for the selected address. A build parameter picks one of two address layouts, so the same block fits either existing software convention. Two level interrupt outputs, one for the seconds tick and one for the alarm, are each the flag gated by its enable.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset the counter, alarm, divider/trim and status registers all read 0 and both interrupt outputs are low.
- R2: Status bit 0 is the alarm flag and bit 1 the tick flag; writing 1 to either bit clears that flag, writing 0 leaves it unchanged.
- R3: Status bit 2 (alarm enable) and bit 3 (tick enable) take the written value on every status write and read back as written.
- R4: With divide field D (bits 15:0 of the divider/trim register) a seconds tick occurs once every D+1 reference pulses counted from reset; D = 0 behaves as D = 32767.
- R5: The tick flag sets on every seconds tick; a status write that clears it in the same cycle as a tick leaves it set.
- R6: The counter increments by one on each seconds tick; a counter write loads the written value, and wins over a tick in the same cycle.
- R7: The alarm flag sets when a tick advances the counter to a value equal to the alarm register; loading that value by a counter write does not set it.
- R8: The tick interrupt is high exactly when status bits 1 and 3 are both set; the alarm interrupt is high exactly when bits 0 and 2 are both set.
- R9: The divider/trim register holds the divide value in bits 15:0 and the trim value in bits 31:16 and reads back what was written; the trim value has no effect on timing.
- R10: With MAP_SEL = 0 the alarm is at 0x00, the counter at 0x04, divider/trim at 0x08 and status at 0x10.
- R11: With MAP_SEL = 1 the counter is at 0x0, the alarm at 0x4, status at 0x8 and divider/trim at 0xC.
- R12: A read of an address outside the selected map returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the selected address, 0 when unselected or unmapped |
| irq_tick | output | 1 | Seconds tick interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The assertions assume the reference pulse never wraps the prescaler on two consecutive clock cycles, which holds because the effective divide value is never below one, and that the alarm register is not rewritten on the same edge the alarm fires. The stimulus keeps to this: it drives reference pulses one per cycle only through a counted task, writes the alarm only while no pulses are applied, and places every collision it wants (status clear against tick, counter load against tick) on the exact cycle of the wrapping pulse, counted from a known reset phase.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

   // status word bit positions (software decodes these)
   localparam int ST_ALARM_FLAG = 0;
   localparam int ST_TICK_FLAG  = 1;
   localparam int ST_ALARM_EN   = 2;
   localparam int ST_TICK_EN    = 3;
   localparam int ST_W          = 4;

   typedef enum logic [1:0] {
      REG_CNT,
      REG_ALM,
      REG_DIV,
      REG_STS
   } reg_id_e;

   typedef struct packed {
      logic tick_en;
      logic alarm_en;
      logic tick_flag;
      logic alarm_flag;
   } status_t;

endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
   import rtc_alarm_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int MAP_SEL = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output reg_id_e           id
);

   generate
      if (MAP_SEL != 0 && MAP_SEL != 1) begin : g_bad_map
         $error("rtc_addr_decode: MAP_SEL must be 0 or 1");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("rtc_addr_decode: ADDR_W must be at least 5");
      end

      if (MAP_SEL == 0) begin : g_map_a
         localparam logic [ADDR_W-1:0] A_ALM = ADDR_W'(32'h00);
         localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(32'h04);
         localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(32'h08);
         localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(32'h10);
         always_comb begin
            hit = 1'b1;
            id  = REG_CNT;
            case (addr)
               A_ALM:   id = REG_ALM;
               A_CNT:   id = REG_CNT;
               A_DIV:   id = REG_DIV;
               A_STS:   id = REG_STS;
               default: hit = 1'b0;
            endcase
         end
      end else begin : g_map_b
         localparam logic [ADDR_W-1:0] B_CNT = ADDR_W'(32'h0);
         localparam logic [ADDR_W-1:0] B_ALM = ADDR_W'(32'h4);
         localparam logic [ADDR_W-1:0] B_STS = ADDR_W'(32'h8);
         localparam logic [ADDR_W-1:0] B_DIV = ADDR_W'(32'hC);
         always_comb begin
            hit = 1'b1;
            id  = REG_CNT;
            case (addr)
               B_CNT:   id = REG_CNT;
               B_ALM:   id = REG_ALM;
               B_STS:   id = REG_STS;
               B_DIV:   id = REG_DIV;
               default: hit = 1'b0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV_W    = 16,
   parameter int DIV_DFLT = 32767
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic [DIV_W-1:0] div_val,
   output logic             sec_tick
);

   generate
      if (DIV_DFLT < 1 || DIV_DFLT >= (1 << DIV_W)) begin : g_bad_dflt
         $error("rtc_prescaler: DIV_DFLT must be in 1 .. 2**DIV_W-1");
      end
   endgenerate

   localparam logic [DIV_W-1:0] DFLT = DIV_W'(DIV_DFLT);
   localparam logic [DIV_W-1:0] ONE  = DIV_W'(1);

   logic [DIV_W-1:0] phase_q;
   logic [DIV_W-1:0] limit;
   logic             at_limit;

   // a zero field falls back to the nominal one-second divide
   assign limit    = (div_val == '0) ? DFLT : div_val;
   // >= so that lowering the divide below the current phase wraps at once
   assign at_limit = (phase_q >= limit);
   assign sec_tick = ref_tick & at_limit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (ref_tick) begin
         phase_q <= at_limit ? '0 : phase_q + ONE;
      end
   end

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] alarm_val,
   output logic [CNT_W-1:0] count,
   output logic             alarm_hit
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_inc;

   assign count_inc = count_q + ONE;
   // only a tick-driven advance can raise the alarm, never a load
   assign alarm_hit = sec_tick & ~load & (count_inc == alarm_val);
   assign count     = count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= load_val;
      end else if (sec_tick) begin
         count_q <= count_inc;
      end
   end

endmodule

// File: rtl/rtc_status.sv
module rtc_status
   import rtc_alarm_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [ST_W-1:0] wbits,
   input  logic            tick_set,
   input  logic            alarm_set,
   output status_t         status
);

   status_t st_q;
   status_t st_d;

   always_comb begin
      st_d = st_q;
      if (wr) begin
         st_d.alarm_en = wbits[ST_ALARM_EN];
         st_d.tick_en  = wbits[ST_TICK_EN];
         if (wbits[ST_ALARM_FLAG]) st_d.alarm_flag = 1'b0;
         if (wbits[ST_TICK_FLAG])  st_d.tick_flag  = 1'b0;
      end
      // a new event outranks a clear landing on the same edge
      if (alarm_set) st_d.alarm_flag = 1'b1;
      if (tick_set)  st_d.tick_flag  = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         st_q <= st_d;
      end
   end

   assign status = st_q;

endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
   import rtc_alarm_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 32,
   parameter int DIV_W    = 16,
   parameter int TRIM_W   = 16,
   parameter int DIV_DFLT = 32767,
   parameter int MAP_SEL  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_tick,
   output logic              irq_alarm
);

   localparam int DT_W = DIV_W + TRIM_W;

   generate
      if (DATA_W < DT_W) begin : g_bad_dt
         $error("rtc_alarm_top: divider and trim do not fit in DATA_W");
      end
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("rtc_alarm_top: CNT_W must be in 2 .. DATA_W");
      end
      if (DATA_W < ST_W) begin : g_bad_st
         $error("rtc_alarm_top: DATA_W too narrow for status");
      end
   endgenerate

   logic              addr_hit;
   reg_id_e           addr_id;
   logic              wr_any;
   logic              wr_cnt;
   logic              wr_alm;
   logic              wr_div;
   logic              wr_sts;
   logic              sec_tick;
   logic              alarm_hit;
   logic [CNT_W-1:0]  count_q;
   logic [CNT_W-1:0]  alarm_q;
   logic [DIV_W-1:0]  div_q;
   logic [TRIM_W-1:0] trim_q;
   status_t           st_q;

   rtc_addr_decode #(
      .ADDR_W (ADDR_W),
      .MAP_SEL(MAP_SEL)
   ) u_decode (
      .addr(bus_addr),
      .hit (addr_hit),
      .id  (addr_id)
   );

   assign wr_any = bus_sel & bus_wr & addr_hit;
   assign wr_cnt = wr_any & (addr_id == REG_CNT);
   assign wr_alm = wr_any & (addr_id == REG_ALM);
   assign wr_div = wr_any & (addr_id == REG_DIV);
   assign wr_sts = wr_any & (addr_id == REG_STS);

   // alarm value and divider/trim storage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm_q <= '0;
         div_q   <= '0;
         trim_q  <= '0;
      end else begin
         if (wr_alm) alarm_q <= bus_wdata[CNT_W-1:0];
         if (wr_div) begin
            div_q  <= bus_wdata[DIV_W-1:0];
            trim_q <= bus_wdata[DIV_W +: TRIM_W];
         end
      end
   end

   rtc_prescaler #(
      .DIV_W   (DIV_W),
      .DIV_DFLT(DIV_DFLT)
   ) u_prescaler (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_tick(ref_tick),
      .div_val (div_q),
      .sec_tick(sec_tick)
   );

   rtc_sec_counter #(
      .CNT_W(CNT_W)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .load     (wr_cnt),
      .load_val (bus_wdata[CNT_W-1:0]),
      .alarm_val(alarm_q),
      .count    (count_q),
      .alarm_hit(alarm_hit)
   );

   rtc_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_sts),
      .wbits    (bus_wdata[ST_W-1:0]),
      .tick_set (sec_tick),
      .alarm_set(alarm_hit),
      .status   (st_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && addr_hit) begin
         case (addr_id)
            REG_CNT: bus_rdata[CNT_W-1:0] = count_q;
            REG_ALM: bus_rdata[CNT_W-1:0] = alarm_q;
            REG_DIV: bus_rdata[DT_W-1:0]  = {trim_q, div_q};
            REG_STS: bus_rdata[ST_W-1:0]  = st_q;
            default: bus_rdata = '0;
         endcase
      end
   end

   assign irq_tick  = st_q.tick_flag  & st_q.tick_en;
   assign irq_alarm = st_q.alarm_flag & st_q.alarm_en;

endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sec_tick,
   input logic             load,
   input logic [CNT_W-1:0] load_val,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] alarm_val,
   input logic             sts_wr,
   input logic [3:0]       sts_wdata,
   input logic [3:0]       sts,
   input logic             irq_alarm
);

   assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);

   assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !load) |=> (count == $past(count) + CNT_W'(1)));

   assert_count_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(load_val)));

   assert_alarm_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sts[0]) && $stable(alarm_val)) |-> (count == alarm_val));

   assert_enable_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sts_wr |=> (sts[3:2] == $past(sts_wdata[3:2])));

   assert_flag_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts[1]) |-> $past(sts_wr && sts_wdata[1]));

   assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_alarm |-> (sts[2] && sts[0]));

endmodule

bind rtc_alarm_top rtc_alarm_chk #(
   .CNT_W(CNT_W)
) u_rtc_alarm_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sec_tick (sec_tick),
   .load     (wr_cnt),
   .load_val (bus_wdata[CNT_W-1:0]),
   .count    (count_q),
   .alarm_val(alarm_q),
   .sts_wr   (wr_sts),
   .sts_wdata(bus_wdata[3:0]),
   .sts      (st_q),
   .irq_alarm(irq_alarm)
);

// File: tb/test_rtc_alarm_top.sv
module test_rtc_alarm_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        ref_tick_b = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_sel_b = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata_a;
   logic [31:0] rdata_b;
   logic        irq_tick_a, irq_alarm_a;
   logic        irq_tick_b, irq_alarm_b;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   typedef struct {
      int          inst;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];
   logic  mon_req = 1'b0;

   always #2 clk = ~clk;

   rtc_alarm_top #(.MAP_SEL(0)) i_rtc_alarm_top (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
      .irq_tick(irq_tick_a), .irq_alarm(irq_alarm_a));

   rtc_alarm_top #(.MAP_SEL(1)) i_rtc_alarm_top_b (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick_b),
      .bus_sel(bus_sel_b), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
      .irq_tick(irq_tick_b), .irq_alarm(irq_alarm_b));

   // map A addresses
   localparam logic [4:0] A_ALM = 5'h00, A_CNT = 5'h04, A_DIV = 5'h08, A_STS = 5'h10;
   // map B addresses
   localparam logic [4:0] B_CNT = 5'h0, B_ALM = 5'h4, B_STS = 5'h8, B_DIV = 5'hC;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per requested read
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (mon_req && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, (it.inst == 0) ? rdata_a : rdata_b, it.exp);
         end
      end
   end

   task automatic bus_write(input int inst, input logic [4:0] a, input logic [31:0] d,
                            input logic with_ref);
      @(negedge clk);
      bus_sel   = (inst == 0);
      bus_sel_b = (inst != 0);
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      ref_tick  = with_ref;
      @(negedge clk);
      bus_sel   = 1'b0;
      bus_sel_b = 1'b0;
      bus_wr    = 1'b0;
      ref_tick  = 1'b0;
   endtask

   task automatic read_chk(input int inst, input logic [4:0] a, input logic [31:0] exp,
                           input string tag);
      item_t it;
      @(negedge clk);
      bus_sel   = (inst == 0);
      bus_sel_b = (inst != 0);
      bus_wr    = 1'b0;
      bus_addr  = a;
      it.inst = inst;
      it.exp  = exp;
      it.tag  = tag;
      sb_q.push_back(it);
      mon_req = 1'b1;
      @(negedge clk);
      mon_req   = 1'b0;
      bus_sel   = 1'b0;
      bus_sel_b = 1'b0;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ref_tick = 1'b1;
      end
      @(negedge clk);
      ref_tick = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset state
      read_chk(0, A_CNT, 32'h0, "R1 counter");
      read_chk(0, A_ALM, 32'h0, "R1 alarm");
      read_chk(0, A_DIV, 32'h0, "R1 divider");
      read_chk(0, A_STS, 32'h0, "R1 status");
      check("R1 irq_tick", {31'b0, irq_tick_a}, 32'h0);
      check("R1 irq_alarm", {31'b0, irq_alarm_a}, 32'h0);

      // R9: trim stored and read back, divide = 3
      bus_write(0, A_DIV, 32'h1234_0003, 1'b0);
      read_chk(0, A_DIV, 32'h1234_0003, "R9 divider/trim readback");
      bus_write(0, A_ALM, 32'd5, 1'b0);
      bus_write(0, A_CNT, 32'd3, 1'b0);
      read_chk(0, A_ALM, 32'd5, "R10 alarm at 0x00");
      bus_write(0, A_STS, 32'h4, 1'b0);

      // R4/R9: D+1 = 4 pulses per tick despite nonzero trim
      pulses(3);
      read_chk(0, A_CNT, 32'd3, "R4 no tick after 3 pulses");
      pulses(1);
      read_chk(0, A_CNT, 32'd4, "R4 tick on 4th pulse");
      read_chk(0, A_STS, 32'h6, "R5 tick flag set");
      check("R8 irq_tick masked", {31'b0, irq_tick_a}, 32'h0);
      check("R8 irq_alarm idle", {31'b0, irq_alarm_a}, 32'h0);

      // R7: tick reaches alarm value
      pulses(4);
      read_chk(0, A_CNT, 32'd5, "R6 counter advanced");
      read_chk(0, A_STS, 32'h7, "R7 alarm flag set");
      check("R8 irq_alarm raised", {31'b0, irq_alarm_a}, 32'h1);

      // R2: write-one clears alarm flag only
      bus_write(0, A_STS, 32'h5, 1'b0);
      read_chk(0, A_STS, 32'h6, "R2 w1 clears alarm flag");
      check("R8 irq_alarm dropped", {31'b0, irq_alarm_a}, 32'h0);
      bus_write(0, A_STS, 32'h4, 1'b0);
      read_chk(0, A_STS, 32'h6, "R2 w0 leaves tick flag");

      // R7: load equal to alarm does not set flag
      bus_write(0, A_CNT, 32'd5, 1'b0);
      read_chk(0, A_STS, 32'h6, "R7 load does not set alarm");

      // R3: enables follow write
      bus_write(0, A_STS, 32'hA, 1'b0);
      read_chk(0, A_STS, 32'h8, "R3 enables take written value");
      pulses(4);
      read_chk(0, A_CNT, 32'd6, "R6 counter 6");
      read_chk(0, A_STS, 32'hA, "R5 tick flag set again");
      check("R8 irq_tick raised", {31'b0, irq_tick_a}, 32'h1);

      // R5: set beats clear in same cycle
      bus_write(0, A_STS, 32'hA, 1'b0);
      read_chk(0, A_STS, 32'h8, "R2 tick flag cleared");
      pulses(3);
      bus_write(0, A_STS, 32'hA, 1'b1);
      read_chk(0, A_STS, 32'hA, "R5 set wins over clear");
      read_chk(0, A_CNT, 32'd7, "R6 counter 7");

      // R6: load wins over tick
      pulses(3);
      bus_write(0, A_CNT, 32'd100, 1'b1);
      read_chk(0, A_CNT, 32'd100, "R6 load wins over tick");
      pulses(4);
      read_chk(0, A_CNT, 32'd101, "R6 increments after load");

      // R12: unmapped in map A
      read_chk(0, 5'h0C, 32'h0, "R12 unmapped map A");

      // R4: zero divide means 32768 pulses
      do_reset();
      read_chk(0, A_DIV, 32'h0, "R1 divider after reset");
      pulses(32767);
      read_chk(0, A_CNT, 32'd0, "R4 no tick before 32768 pulses");
      pulses(1);
      read_chk(0, A_CNT, 32'd1, "R4 tick at 32768 pulses");

      // R11: map B
      bus_write(1, B_ALM, 32'h55, 1'b0);
      bus_write(1, B_DIV, 32'h0007_0009, 1'b0);
      bus_write(1, B_CNT, 32'h77, 1'b0);
      bus_write(1, B_STS, 32'hC, 1'b0);
      read_chk(1, B_ALM, 32'h55, "R11 alarm at 0x4");
      read_chk(1, B_DIV, 32'h0007_0009, "R11 divider at 0xC");
      read_chk(1, B_CNT, 32'h77, "R11 counter at 0x0");
      read_chk(1, B_STS, 32'hC, "R11 status at 0x8");
      read_chk(1, 5'h10, 32'h0, "R12 unmapped map B");

      repeat (2) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule